// File: doc/BRIEF.md
# Fractional-Period Time-of-Day Counter

This block keeps wall-clock time as a 48-bit count of seconds and a 32-bit count of nanoseconds. A hidden 16-bit sub-nanosecond fraction sits below the nanoseconds. On every clock cycle the block adds a fixed-point step to the time. The step is 20 bits wide: 4 integer nanosecond bits and 16 fraction bits. When the nanosecond part reaches one billion, the block subtracts one billion and adds one to the seconds.

Offsets are corrected smoothly. Software loads a temporary step and a cycle count. The block uses the temporary step in place of the normal step until the count has run down to zero. Frequency error is trimmed by a periodic drift term: a 16-bit fractional-nanosecond amount added to the step once every programmed number of cycles.

A separate register block holds the settings and drives the ports. It also produces the one-cycle strobes. An atomic time load replaces the whole time in a single cycle. The live time and the remaining slew count are outputs.

Top module: `tod_clock_core`

## Requirements
- R1: While `rst_n` is low at a clock edge, the seconds, nanoseconds and remaining slew count all become zero. The internal fraction and the drift cycle counter are also cleared.
- R2: Each cycle without a load, the value {nanoseconds, 16-bit fraction} grows by the active step. The active step has 16 fraction bits, so 0x10000 means 1 ns and 0x08000 means 0.5 ns. The nanosecond output shows the integer part only.
- R3: A pulse on `slew_load_i` captures `slew_step_i` and `slew_count_i`. The block does not use the new step in the cycle of the pulse. For each of the following cycles, while the count is nonzero, the slew step replaces `step_i` and the count drops by one.
- R4: Once the remaining slew count reads zero, it stays at zero and `step_i` is used again.
- R5: When both `drift_rate_i` and `drift_frac_i` are nonzero, `drift_frac_i` is added to the step once every `drift_rate_i` cycles. These are units of 2^-16 ns. With a rate of N, the first injection falls on the N-th cycle after the counter restarts. A rate of zero, or a drift value of zero, stops all injection.
- R6: When the nanosecond value reaches or passes 1,000,000,000, the block subtracts 1,000,000,000 from it and adds one to the seconds. Seconds wrap modulo 2^48.
- R7: A pulse on `time_load_i` sets seconds and nanoseconds to the given values and clears the fraction. It takes priority over that cycle's increment.
- R8: A pulse on `drift_rate_wr_i` resets the drift cycle counter. No drift is injected in that cycle.
- R9: A slew load while a slew is running replaces the remaining count and the step at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_i | input | 20 | Normal step per cycle, 16 fraction bits |
| slew_load_i | input | 1 | Starts an offset slew |
| slew_step_i | input | 20 | Temporary step used while slewing |
| slew_count_i | input | 20 | Number of cycles to slew |
| drift_frac_i | input | 16 | Drift amount in 2^-16 ns |
| drift_rate_i | input | 16 | Cycles between drift injections |
| drift_rate_wr_i | input | 1 | Strobe: drift rate written, restart counter |
| time_load_i | input | 1 | Atomic time load strobe |
| load_sec_i | input | 48 | Seconds to load |
| load_ns_i | input | 32 | Nanoseconds to load |
| tod_sec_o | output | 48 | Live seconds |
| tod_ns_o | output | 32 | Live nanoseconds |
| slew_remaining_o | output | 20 | Remaining slew cycles; zero means done |

## Verification
Directed patterns are used first:
- Whole and half nanosecond steps. These separate integer accumulation from fraction carry, and show that a load throws away a pending half nanosecond.
- A four-cycle slew at 3 ns. This shows exactly which cycles take the temporary step and how the count runs out.
- Drift at a rate of four. Run with drift on and then with drift off, so each injection shows as a whole-nanosecond change.
- A drift restart in the middle of the window. This delays the injection and gives a result that differs from a counter that was never restarted.
- Loads just below one billion nanoseconds, including the top seconds value. These expose the wrap and the seconds roll-over.

Then random steps, slews, drift settings and near-wrap loads run for several thousand cycles. Each cycle is compared against a reference model in the bench.

// File: rtl/tod_pkg.sv
package tod_pkg;
   localparam int TOD_SEC_W   = 48;
   localparam int TOD_NS_W    = 32;
   localparam int TOD_FRAC_W  = 16;
   localparam int TOD_STEP_W  = 20;
   localparam int TOD_CNT_W   = 20;
   localparam int TOD_DRIFT_W = 16;
   localparam int TOD_RATE_W  = 16;
   localparam longint unsigned TOD_NS_PER_SEC = 64'd1000000000;
endpackage

// File: rtl/tod_slew_ctl.sv
module tod_slew_ctl #(
   parameter int STEP_W = tod_pkg::TOD_STEP_W,
   parameter int CNT_W  = tod_pkg::TOD_CNT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [STEP_W-1:0] step_i,
   input  logic              slew_load_i,
   input  logic [STEP_W-1:0] slew_step_i,
   input  logic [CNT_W-1:0]  slew_count_i,
   output logic [STEP_W-1:0] cur_step_o,
   output logic [CNT_W-1:0]  remaining_o
);
   logic [STEP_W-1:0] slew_step_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              active;

   assign active = (cnt_q != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slew_step_q <= '0;
         cnt_q       <= '0;
      end else if (slew_load_i) begin
         slew_step_q <= slew_step_i;
         cnt_q       <= slew_count_i;
      end else if (active) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign cur_step_o  = active ? slew_step_q : step_i;
   assign remaining_o = cnt_q;

   // R3: a running slew counts down by exactly one per cycle
   p_slew_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (remaining_o != '0 && !slew_load_i) |=> remaining_o == $past(remaining_o) - 1'b1);
   // R4: an idle slew stays idle
   p_slew_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (remaining_o == '0 && !slew_load_i) |=> remaining_o == '0);
   // R9: a load overrides whatever count was running
   p_slew_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
      slew_load_i |=> remaining_o == $past(slew_count_i));
endmodule

// File: rtl/tod_drift_gen.sv
module tod_drift_gen #(
   parameter int DRIFT_W = tod_pkg::TOD_DRIFT_W,
   parameter int RATE_W  = tod_pkg::TOD_RATE_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [DRIFT_W-1:0] drift_frac_i,
   input  logic [RATE_W-1:0]  drift_rate_i,
   input  logic               drift_rate_wr_i,
   output logic [DRIFT_W-1:0] inject_o
);
   logic [RATE_W-1:0] cnt_q;
   logic              enabled;
   logic              fire;

   assign enabled = (drift_rate_i != '0) && (drift_frac_i != '0);
   assign fire    = enabled && !drift_rate_wr_i && (cnt_q >= drift_rate_i - 1'b1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (drift_rate_wr_i || !enabled || fire) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign inject_o = fire ? drift_frac_i : '0;

   // R5: while enabled and undisturbed the counter stays below the rate
   p_drift_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (enabled && !drift_rate_wr_i && $stable(drift_rate_i) && cnt_q < drift_rate_i)
      |=> cnt_q < $past(drift_rate_i));
   // R8: a rate write restarts the window
   p_drift_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
      drift_rate_wr_i |=> cnt_q == '0);
   // R5: disabled drift injects nothing
   p_drift_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (drift_rate_i == '0) |-> inject_o == '0);
endmodule

// File: rtl/tod_time_accum.sv
module tod_time_accum #(
   parameter int              SEC_W   = tod_pkg::TOD_SEC_W,
   parameter int              NS_W    = tod_pkg::TOD_NS_W,
   parameter int              FRAC_W  = tod_pkg::TOD_FRAC_W,
   parameter int              INC_W   = tod_pkg::TOD_STEP_W + 1,
   parameter longint unsigned NS_WRAP = tod_pkg::TOD_NS_PER_SEC
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [INC_W-1:0]  inc_i,
   input  logic              time_load_i,
   input  logic [SEC_W-1:0]  load_sec_i,
   input  logic [NS_W-1:0]   load_ns_i,
   output logic [SEC_W-1:0]  sec_o,
   output logic [NS_W-1:0]   ns_o
);
   localparam int ACC_W = NS_W + FRAC_W;
   localparam int SUM_W = ACC_W + 1;
   localparam logic [SUM_W-1:0] WRAP_FULL = SUM_W'(NS_WRAP) << FRAC_W;

   logic [ACC_W-1:0] acc_q;
   logic [SEC_W-1:0] sec_q;
   logic [SUM_W-1:0] sum;
   logic             carry;

   assign sum   = {1'b0, acc_q} + SUM_W'(inc_i);
   assign carry = (sum >= WRAP_FULL);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q <= '0;
         sec_q <= '0;
      end else if (time_load_i) begin
         acc_q <= {load_ns_i, {FRAC_W{1'b0}}};
         sec_q <= load_sec_i;
      end else if (carry) begin
         acc_q <= ACC_W'(sum - WRAP_FULL);
         sec_q <= sec_q + 1'b1;
      end else begin
         acc_q <= sum[ACC_W-1:0];
      end
   end

   assign sec_o = sec_q;
   assign ns_o  = acc_q[ACC_W-1:FRAC_W];

   // R7: load takes effect exactly
   p_load_exact_r7: assert property (@(posedge clk) disable iff (!rst_n)
      time_load_i |=> (ns_o == $past(load_ns_i)) && (sec_o == $past(load_sec_i)));
   // R6: seconds move by at most one per cycle
   p_sec_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !time_load_i |=> (sec_o == $past(sec_o)) || (sec_o == $past(sec_o) + 1'b1));
   // R6: nanoseconds stay in range once in range
   p_ns_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!time_load_i && ns_o < NS_W'(NS_WRAP)) |=> ns_o < NS_W'(NS_WRAP));
endmodule

// File: rtl/tod_clock_core.sv
module tod_clock_core #(
   parameter int              SEC_W   = tod_pkg::TOD_SEC_W,
   parameter int              NS_W    = tod_pkg::TOD_NS_W,
   parameter int              FRAC_W  = tod_pkg::TOD_FRAC_W,
   parameter int              STEP_W  = tod_pkg::TOD_STEP_W,
   parameter int              CNT_W   = tod_pkg::TOD_CNT_W,
   parameter int              DRIFT_W = tod_pkg::TOD_DRIFT_W,
   parameter int              RATE_W  = tod_pkg::TOD_RATE_W,
   parameter longint unsigned NS_WRAP = tod_pkg::TOD_NS_PER_SEC
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [STEP_W-1:0]  step_i,
   input  logic               slew_load_i,
   input  logic [STEP_W-1:0]  slew_step_i,
   input  logic [CNT_W-1:0]   slew_count_i,
   input  logic [DRIFT_W-1:0] drift_frac_i,
   input  logic [RATE_W-1:0]  drift_rate_i,
   input  logic               drift_rate_wr_i,
   input  logic               time_load_i,
   input  logic [SEC_W-1:0]   load_sec_i,
   input  logic [NS_W-1:0]    load_ns_i,
   output logic [SEC_W-1:0]   tod_sec_o,
   output logic [NS_W-1:0]    tod_ns_o,
   output logic [CNT_W-1:0]   slew_remaining_o
);
   localparam int INC_W = ((STEP_W > DRIFT_W) ? STEP_W : DRIFT_W) + 1;

   if (FRAC_W >= STEP_W) begin : g_bad_frac
      $error("step needs integer bits above the fraction");
   end
   if (DRIFT_W > FRAC_W) begin : g_bad_drift
      $error("drift term must be purely fractional");
   end
   if (NS_W < 30 || NS_W > 63) begin : g_bad_ns
      $error("nanosecond width cannot hold one second");
   end

   logic [STEP_W-1:0]  cur_step;
   logic [DRIFT_W-1:0] inject;
   logic [INC_W-1:0]   inc;

   tod_slew_ctl #(.STEP_W(STEP_W), .CNT_W(CNT_W)) u_slew (
      .clk          (clk),
      .rst_n        (rst_n),
      .step_i       (step_i),
      .slew_load_i  (slew_load_i),
      .slew_step_i  (slew_step_i),
      .slew_count_i (slew_count_i),
      .cur_step_o   (cur_step),
      .remaining_o  (slew_remaining_o)
   );

   tod_drift_gen #(.DRIFT_W(DRIFT_W), .RATE_W(RATE_W)) u_drift (
      .clk             (clk),
      .rst_n           (rst_n),
      .drift_frac_i    (drift_frac_i),
      .drift_rate_i    (drift_rate_i),
      .drift_rate_wr_i (drift_rate_wr_i),
      .inject_o        (inject)
   );

   assign inc = INC_W'(cur_step) + INC_W'(inject);

   tod_time_accum #(
      .SEC_W(SEC_W), .NS_W(NS_W), .FRAC_W(FRAC_W), .INC_W(INC_W), .NS_WRAP(NS_WRAP)
   ) u_accum (
      .clk         (clk),
      .rst_n       (rst_n),
      .inc_i       (inc),
      .time_load_i (time_load_i),
      .load_sec_i  (load_sec_i),
      .load_ns_i   (load_ns_i),
      .sec_o       (tod_sec_o),
      .ns_o        (tod_ns_o)
   );

   // R2: with no load, no slew and drift off, time never goes backwards within a second
   p_monotonic_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!time_load_i && drift_rate_i == '0 && tod_ns_o < NS_W'(NS_WRAP - 64'd32))
      |=> (tod_ns_o >= $past(tod_ns_o)) && (tod_sec_o == $past(tod_sec_o)));
endmodule

// File: tb/tod_clock_core_tb.sv
module tod_clock_core_tb;
   localparam longint unsigned WRAP64 = 64'd1000000000 << 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [19:0] step_i = '0;
   logic        slew_load_i = 1'b0;
   logic [19:0] slew_step_i = '0;
   logic [19:0] slew_count_i = '0;
   logic [15:0] drift_frac_i = '0;
   logic [15:0] drift_rate_i = '0;
   logic        drift_rate_wr_i = 1'b0;
   logic        time_load_i = 1'b0;
   logic [47:0] load_sec_i = '0;
   logic [31:0] load_ns_i = '0;
   logic [47:0] tod_sec_o;
   logic [31:0] tod_ns_o;
   logic [19:0] slew_remaining_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   tod_clock_core u_dut (
      .clk(clk), .rst_n(rst_n), .step_i(step_i),
      .slew_load_i(slew_load_i), .slew_step_i(slew_step_i), .slew_count_i(slew_count_i),
      .drift_frac_i(drift_frac_i), .drift_rate_i(drift_rate_i), .drift_rate_wr_i(drift_rate_wr_i),
      .time_load_i(time_load_i), .load_sec_i(load_sec_i), .load_ns_i(load_ns_i),
      .tod_sec_o(tod_sec_o), .tod_ns_o(tod_ns_o), .slew_remaining_o(slew_remaining_o)
   );

   // reference model built from the requirements
   logic [47:0]     m_sec = '0;
   longint unsigned m_acc = 0;
   logic [19:0]     m_cnt = '0;
   logic [19:0]     m_sstep = '0;
   int unsigned     m_dcnt = 0;

   always @(posedge clk) begin : model
      longint unsigned stp;
      bit fire;
      if (!rst_n) begin
         m_sec = '0; m_acc = 0; m_cnt = '0; m_sstep = '0; m_dcnt = 0;
      end else begin
         stp  = (m_cnt != 0) ? longint'(m_sstep) : longint'(step_i);
         fire = 1'b0;
         if (drift_rate_wr_i) m_dcnt = 0;
         else if (drift_rate_i != 0 && drift_frac_i != 0) begin
            if (m_dcnt >= int'(drift_rate_i) - 1) begin fire = 1'b1; m_dcnt = 0; end
            else m_dcnt = m_dcnt + 1;
         end else m_dcnt = 0;
         if (fire) stp = stp + longint'(drift_frac_i);
         if (time_load_i) begin
            m_sec = load_sec_i;
            m_acc = longint'(load_ns_i) << 16;
         end else begin
            m_acc = m_acc + stp;
            if (m_acc >= WRAP64) begin m_acc = m_acc - WRAP64; m_sec = m_sec + 48'd1; end
         end
         if (slew_load_i) begin m_sstep = slew_step_i; m_cnt = slew_count_i; end
         else if (m_cnt != 0) m_cnt = m_cnt - 20'd1;
      end
   end

   task automatic chk(string req, longint unsigned act, longint unsigned exp, string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic load_time(logic [47:0] s, logic [31:0] ns);
      time_load_i = 1'b1; load_sec_i = s; load_ns_i = ns;
      cyc(1);
      time_load_i = 1'b0;
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin : stim
      void'($urandom(32'd5521));
      cyc(3);
      // R1 reset state
      chk("R1", tod_sec_o, 0, "sec in reset");
      chk("R1", tod_ns_o, 0, "ns in reset");
      chk("R1", slew_remaining_o, 0, "slew count in reset");
      rst_n = 1'b1;

      // R7 load and R2 integer step
      step_i = 20'h10000;
      load_time(48'd5, 32'd100);
      chk("R7", tod_sec_o, 5, "loaded sec");
      chk("R7", tod_ns_o, 100, "loaded ns");
      cyc(10);
      chk("R2", tod_ns_o, 110, "ns after ten 1ns steps");

      // R2 half-ns step
      step_i = 20'h08000;
      load_time(48'd5, 32'd0);
      cyc(3);
      chk("R2", tod_ns_o, 1, "ns after three 0.5ns steps");
      cyc(1);
      chk("R2", tod_ns_o, 2, "ns after four 0.5ns steps");
      // R7 load clears the fraction
      load_time(48'd5, 32'd0);
      cyc(1);
      load_time(48'd5, 32'd0);
      cyc(1);
      chk("R7", tod_ns_o, 0, "fraction cleared by load");

      // R3 / R4 slew
      step_i = 20'h10000;
      load_time(48'd1, 32'd0);
      slew_load_i = 1'b1; slew_step_i = 20'h30000; slew_count_i = 20'd4;
      cyc(1);
      slew_load_i = 1'b0;
      chk("R3", tod_ns_o, 1, "normal step in slew load cycle");
      chk("R3", slew_remaining_o, 4, "count after slew load");
      cyc(2);
      chk("R3", tod_ns_o, 7, "ns after two slew cycles");
      chk("R3", slew_remaining_o, 2, "count after two slew cycles");
      cyc(2);
      chk("R3", tod_ns_o, 13, "ns after four slew cycles");
      chk("R4", slew_remaining_o, 0, "count finished");
      cyc(1);
      chk("R4", tod_ns_o, 14, "normal step after slew");
      chk("R4", slew_remaining_o, 0, "count stays zero");

      // R9 reload mid-slew
      slew_load_i = 1'b1; slew_step_i = 20'h20000; slew_count_i = 20'd10;
      cyc(1);
      slew_load_i = 1'b0;
      cyc(3);
      chk("R9", slew_remaining_o, 7, "count mid slew");
      slew_load_i = 1'b1; slew_count_i = 20'd2;
      cyc(1);
      slew_load_i = 1'b0;
      chk("R9", slew_remaining_o, 2, "count after reload");
      cyc(3);

      // R5 drift every 4 cycles of 0.5ns
      drift_frac_i = 16'h8000; drift_rate_i = 16'd4; drift_rate_wr_i = 1'b1;
      load_time(48'd2, 32'd0);
      drift_rate_wr_i = 1'b0;
      cyc(4);
      chk("R5", tod_ns_o, 4, "ns after first drift window");
      cyc(4);
      chk("R5", tod_ns_o, 9, "ns after two drift injections");
      drift_frac_i = 16'h0000;
      cyc(8);
      chk("R5", tod_ns_o, 17, "no drift with zero value");
      drift_frac_i = 16'h8000; drift_rate_i = 16'd0;
      cyc(8);
      chk("R5", tod_ns_o, 25, "no drift with zero rate");

      // R8 restart of the drift window
      drift_rate_i = 16'd4; drift_rate_wr_i = 1'b1;
      load_time(48'd2, 32'd0);
      drift_rate_wr_i = 1'b0;
      cyc(3);
      drift_rate_wr_i = 1'b1;
      cyc(1);
      drift_rate_wr_i = 1'b0;
      chk("R8", tod_ns_o, 4, "no injection on restart cycle");
      cyc(4);
      chk("R8", tod_ns_o, 8, "injection delayed by restart");
      drift_rate_i = 16'd0;

      // R6 wrap
      step_i = 20'h10000;
      load_time(48'd7, 32'd999999998);
      cyc(1);
      chk("R6", tod_ns_o, 999999999, "just below wrap");
      cyc(1);
      chk("R6", tod_ns_o, 0, "ns wrapped");
      chk("R6", tod_sec_o, 8, "sec carried");
      load_time(48'hFFFF_FFFF_FFFF, 32'd999999999);
      cyc(1);
      chk("R6", tod_sec_o, 0, "seconds roll over");
      chk("R6", tod_ns_o, 0, "ns after roll over");

      // random phase against the model
      for (int i = 0; i < 4000; i++) begin
         int r = int'($urandom % 100);
         slew_load_i = 1'b0; time_load_i = 1'b0; drift_rate_wr_i = 1'b0;
         if (r < 3) step_i = 20'($urandom);
         else if (r < 6) begin
            slew_load_i = 1'b1; slew_step_i = 20'($urandom); slew_count_i = 20'($urandom % 40);
         end else if (r < 8) begin
            drift_rate_wr_i = 1'b1; drift_rate_i = 16'($urandom % 9); drift_frac_i = 16'($urandom);
         end else if (r < 10) begin
            time_load_i = 1'b1; load_sec_i = 48'($urandom);
            load_ns_i = 32'd1000000000 - 32'($urandom % 200) - 32'd1;
         end
         cyc(1);
         chk("R2", tod_ns_o, m_acc >> 16, "random ns");
         chk("R6", tod_sec_o, m_sec, "random sec");
         chk("R3", slew_remaining_o, m_cnt, "random slew count");
      end
      slew_load_i = 1'b0; time_load_i = 1'b0; drift_rate_wr_i = 1'b0;
      cyc(2);
      finish_run();
   end
endmodule